// File: doc/BRIEF.md
# Seven-Bit Bidirectional GPIO Port

This block controls seven general-purpose pins from a small register bus. Software sets each pin's direction, writes an output latch, and reads either the latch or the live pin levels. The live levels pass through a two-stage synchronizer before they reach the read path. Because the latch has its own readback, a read-modify-write of the outputs never depends on what the pins happen to show.

Two neighbouring blocks share the pins. An external configuration register supplies a per-pin analog-select mask, and a pin selected as analog reads as zero through the port address. Bit 4 is special. It has an open-drain driver, its synchronized level goes out as a clock for a timer, and a peripheral can take over its driver. The pad drivers themselves sit outside the block and see only a value and an enable for each pin.

Top module: `gpio7_port`

## Requirements
- R1: For each pin other than bit 4, a direction bit of 1 deasserts `pin_oe` (input, driver off), and a direction bit of 0 asserts `pin_oe` with `pin_out` equal to that pin's latch bit.
- R2: Bus address 0 (port) reads the pin levels after two clock stages. A change on `pin_in` is not visible one clock later and is visible two clocks later.
- R3: A write to address 0 or to address 1 (latch) loads the output latch. A read of address 1 returns the latch, whatever the pin levels are.
- R4: Reset (synchronous, active high) sets every direction bit to 1, so all `pin_oe` are 0. It also sets the latch to 0 and clears the synchronizer.
- R5: Through address 0, every bit whose `ana_sel` bit is 1 reads as 0. Reads of the latch at address 1 are unaffected.
- R6: Bit 4 is open-drain. Its `pin_oe` is 1 only when its direction bit is 0 and its latch bit is 0, and `pin_oe[4]` is never 1 while `pin_out[4]` is 1.
- R7: While `ovr_en` is 1, bit 4 follows `ovr_val` whatever its direction and latch bits are. A value of 0 pulls the pin low and a value of 1 releases it.
- R8: Address 3 reads as 0. A write to it changes neither the latch, nor the direction register, nor any pin output.
- R9: `periph_clk` carries the synchronized level of pin 4, and the analog mask does not affect it.
- R10: The direction bits keep control of the drivers while pins are selected as analog.
- R11: Address 2 (direction) reads back the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 7 | Read data for `bus_addr` (combinational) |
| pin_in | input | 7 | Raw pin levels from the pads |
| pin_out | output | 7 | Output value to the pads |
| pin_oe | output | 7 | Output enable to the pads |
| ana_sel | input | 7 | Per-pin analog-select mask |
| ovr_en | input | 1 | Peripheral takes over the bit-4 driver |
| ovr_val | input | 1 | Bit-4 value while overridden |
| periph_clk | output | 1 | Synchronized pin-4 level for the timer |

## Verification
The hardest case to reach from the ports is a pin that is analog-selected and also driven as an output. Its level must read as zero at the port address while its latch still reads back and its driver stays enabled. The vector table reaches this case by clearing the direction bits, writing the latch and raising analog bits in a single vector. The bench then waits out the synchronizer before it reads both addresses. For the synchronizer depth, a directed test toggles every pin at a falling edge and reads the port address after one clock and again after two.

// File: rtl/gpio7_pkg.sv
package gpio7_pkg;
    localparam int PW          = 7;
    localparam int AW          = 2;
    localparam int OD_BIT      = 4;
    localparam int SYNC_STAGES = 2;

    typedef logic [PW-1:0] pvec_t;

    typedef enum logic [AW-1:0] {
        ADR_PORT  = 2'd0,
        ADR_LATCH = 2'd1,
        ADR_DIR   = 2'd2,
        ADR_NONE  = 2'd3
    } adr_e;

    typedef struct packed {
        pvec_t lat;
        pvec_t dir;
    } regs_t;

    typedef struct packed {
        pvec_t val;
        pvec_t oe;
    } drv_t;

    function automatic pvec_t od_mask();
        pvec_t m;
        m = '0;
        m[OD_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/gpio7_sync.sv
module gpio7_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio7_regs.sv
module gpio7_regs
    import gpio7_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  pvec_t         wdata,
    input  pvec_t         pins_sync,
    input  pvec_t         ana,
    output pvec_t         rdata,
    output regs_t         regs
);
    adr_e  sel;
    regs_t r_q;

    assign sel = adr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.lat <= '0;
            r_q.dir <= '1;
        end else if (we) begin
            case (sel)
                ADR_PORT, ADR_LATCH: r_q.lat <= wdata;
                ADR_DIR:             r_q.dir <= wdata;
                default:             ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            ADR_PORT:  rdata = pins_sync & ~ana;
            ADR_LATCH: rdata = r_q.lat;
            ADR_DIR:   rdata = r_q.dir;
            default:   rdata = '0;
        endcase
    end

    assign regs = r_q;
endmodule

// File: rtl/gpio7_pad.sv
module gpio7_pad
    import gpio7_pkg::*;
(
    input  regs_t regs,
    input  logic  ovr_en,
    input  logic  ovr_val,
    output drv_t  drv
);
    for (genvar i = 0; i < PW; i++) begin : g_bit
        if (i == OD_BIT) begin : g_od
            always_comb begin
                if (ovr_en) begin
                    drv.val[i] = ovr_val;
                    drv.oe[i]  = ~ovr_val;
                end else begin
                    drv.val[i] = regs.lat[i];
                    drv.oe[i]  = ~regs.dir[i] & ~regs.lat[i];
                end
            end
        end else begin : g_pp
            always_comb begin
                drv.val[i] = regs.lat[i];
                drv.oe[i]  = ~regs.dir[i];
            end
        end
    end
endmodule

// File: rtl/gpio7_port.sv
module gpio7_port
    import gpio7_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_we,
    input  logic [6:0] bus_wdata,
    output logic [6:0] bus_rdata,
    input  logic [6:0] pin_in,
    output logic [6:0] pin_out,
    output logic [6:0] pin_oe,
    input  logic [6:0] ana_sel,
    input  logic       ovr_en,
    input  logic       ovr_val,
    output logic       periph_clk
);
    pvec_t pins_sync;
    regs_t regs;
    drv_t  drv;

    gpio7_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_sync)
    );

    gpio7_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .pins_sync (pins_sync),
        .ana       (ana_sel),
        .rdata     (bus_rdata),
        .regs      (regs)
    );

    gpio7_pad u_pad (
        .regs    (regs),
        .ovr_en  (ovr_en),
        .ovr_val (ovr_val),
        .drv     (drv)
    );

    assign pin_out    = drv.val;
    assign pin_oe     = drv.oe;
    assign periph_clk = pins_sync[OD_BIT];
endmodule

// File: rtl/gpio7_checker.sv
module gpio7_checker
    import gpio7_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] bus_addr,
    input logic       bus_we,
    input logic [6:0] bus_wdata,
    input logic [6:0] bus_rdata,
    input logic [6:0] pin_in,
    input logic [6:0] pin_out,
    input logic [6:0] pin_oe,
    input logic [6:0] ana_sel,
    input logic       ovr_en,
    input logic       ovr_val,
    input logic       periph_clk
);
    localparam pvec_t ODM = od_mask();
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0)); // R4
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        pin_oe[OD_BIT] |-> !pin_out[OD_BIT]); // R6
    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd1) |=> ((pin_out & ~ODM) == ($past(bus_wdata) & ~ODM))); // R3
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd2) |=> ((pin_oe & ~ODM) == (~$past(bus_wdata) & ~ODM))); // R1
    AST_ANALOG_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> ((bus_rdata & ana_sel) == '0)); // R5
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> (bus_rdata == '0)); // R8
    AST_UNUSED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 2'd3) |=> ($stable(pin_out & ~ODM) && $stable(pin_oe & ~ODM))); // R8
    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && bus_addr == 2'd0) |-> (bus_rdata == ($past(pin_in, 2) & ~ana_sel))); // R2
    AST_LATCH_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1 && !ovr_en) |-> (bus_rdata == pin_out)); // R3
    AST_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        ovr_en |-> (pin_oe[OD_BIT] == !ovr_val)); // R7
    AST_PCLK: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (periph_clk == $past(pin_in[OD_BIT], 2))); // R9
endmodule

bind gpio7_port gpio7_checker u_chk (.*);

// File: tb/sim_gpio7_port.sv
module sim_gpio7_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [6:0] bus_wdata = '0;
    logic [6:0] bus_rdata;
    logic [6:0] pin_in = '0;
    logic [6:0] pin_out;
    logic [6:0] pin_oe;
    logic [6:0] ana_sel = '0;
    logic       ovr_en = 1'b0;
    logic       ovr_val = 1'b0;
    logic       periph_clk;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio7_port u0 (.*);

    // fields: dir, latch, pins, ana, expected port read, expected oe
    localparam int NV = 6;
    localparam logic [41:0] VECS [NV] = '{
        {7'h7F, 7'h00, 7'h55, 7'h00, 7'h55, 7'h00},
        {7'h00, 7'h2A, 7'h7F, 7'h2F, 7'h50, 7'h7F},
        {7'h00, 7'h7F, 7'h00, 7'h00, 7'h00, 7'h6F},
        {7'h0F, 7'h15, 7'h3C, 7'h21, 7'h1C, 7'h60},
        {7'h6F, 7'h00, 7'h10, 7'h7F, 7'h00, 7'h10},
        {7'h55, 7'h6A, 7'h2B, 7'h40, 7'h2B, 7'h2A}
    };

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [6:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [6:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        logic [6:0] v;
        pin_in = 7'h7F;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4: reset state
        chk("R4 oe", pin_oe, 7'h00);
        rd(2'd1, v); chk("R4 latch", v, 7'h00);
        rd(2'd2, v); chk("R4/R11 dir", v, 7'h7F);

        // table walk: R1 R3 R5 R6 R9 R10
        for (int i = 0; i < NV; i++) begin
            logic [6:0] dir, lat, pins, ana, eport, eoe;
            {dir, lat, pins, ana, eport, eoe} = VECS[i];
            wr(2'd2, dir);
            wr((i % 2 == 1) ? 2'd1 : 2'd0, lat); // R3 both write addresses
            pin_in = pins; ana_sel = ana;
            repeat (3) @(negedge clk);
            rd(2'd0, v); chk("R2/R5 port read", v, eport);
            rd(2'd1, v); chk("R3 latch read", v, lat);
            rd(2'd2, v); chk("R11 dir read", v, dir);
            chk("R1/R6/R10 oe", pin_oe, eoe);
            chk("R1 out", pin_out, lat);
            chk("R9 periph_clk", {6'd0, periph_clk}, {6'd0, pins[4]});
            chk("R6 od never high", {6'd0, pin_oe[4] & pin_out[4]}, 7'h00);
        end

        // R2: two-stage delay
        ana_sel = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        bus_addr = 2'd0;
        pin_in = 7'h7F;
        @(negedge clk); rd(2'd0, v); chk("R2 one clock", v, 7'h00);
        @(negedge clk); rd(2'd0, v); chk("R2 two clocks", v, 7'h7F);

        // R8: unused address
        wr(2'd2, 7'h00);
        wr(2'd1, 7'h33);
        wr(2'd3, 7'h4C);
        rd(2'd3, v); chk("R8 read zero", v, 7'h00);
        rd(2'd1, v); chk("R8 latch kept", v, 7'h33);
        rd(2'd2, v); chk("R8 dir kept", v, 7'h00);
        chk("R8 out kept", pin_out, 7'h33);

        // R7: override on bit 4 with pin configured as input
        wr(2'd2, 7'h7F);
        @(negedge clk);
        ovr_en = 1'b1; ovr_val = 1'b0;
        #1;
        chk("R7 pull low oe", pin_oe, 7'h10);
        chk("R7 pull low val", {6'd0, pin_out[4]}, 7'h00);
        ovr_val = 1'b1;
        #1;
        chk("R7 release", pin_oe, 7'h00);
        ovr_en = 1'b0;

        // R3: latch read independent of pins
        wr(2'd1, 7'h5A);
        pin_in = 7'h25;
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R3 latch vs pins", v, 7'h5A);

        // R4: reset in mid-operation
        wr(2'd2, 7'h00);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R4 oe after rst", pin_oe, 7'h00);
        rd(2'd1, v); chk("R4 latch after rst", v, 7'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule